// File: doc/BRIEF.md
# Receive Descriptor Ownership Poller

This block tracks which receive buffers a descriptor-ring network controller currently holds, on the receive side only. On each poll tick it reads ownership flags of descriptors through a single memory read port. It keeps a two-entry ownership cache: one entry for the current descriptor and one for the descriptor after it. The controller reads only the entries it does not already own. When it owns both, or owns the current one in a single-entry ring, a poll tick issues no read at all.

When a frame starts, the block waits for the address filter's verdict. If the frame is rejected, the block touches no descriptor. An accepted frame uses the cached flag for the current buffer. If that buffer is not held, the block makes one last-ditch read of the current descriptor. If this read also finds the buffer unavailable, the block raises a sticky missed-frame flag and, if the interrupt enable and mask allow it, an interrupt. It then ignores every poll until the frame ends.

The data path hands a filled buffer back with a release strobe. The release advances the ring index modulo the ring length and moves the cached next ownership into the current slot.

Top module: `rx_own_poller`

## Requirements
- R1: After reset, rd_req, miss and irq are 0, cur_idx is 0, cur_owned is 0 and engaged is 0.
- R2: A poll tick reads descriptor cur_idx if it is not cached as owned. It then reads descriptor (cur_idx+1) mod length if that one is not cached as owned and the ring holds more than one entry. Each read is a one-cycle rd_req pulse carrying rd_idx.
- R3: With ring_last = 0 (ring length 1), no descriptor other than index 0 is ever read.
- R4: A poll tick issues no read while the current and the next descriptor are both cached as owned, or while the current one is owned in a single-entry ring.
- R5: Between frame_start and addr_done the block issues no read. A frame with addr_accept = 0 causes no read and leaves miss unchanged.
- R6: An accepted frame whose current buffer is cached as owned causes no read and does not set miss.
- R7: An accepted frame whose current buffer is not cached as owned causes exactly one read of cur_idx. If rd_own = 1 comes back, cur_owned becomes 1 and miss stays 0.
- R8: If that last-ditch read returns rd_own = 0, miss becomes 1 and stays 1. irq is 1 exactly when miss = 1, irq_en = 1 and miss_mask = 0 (irq follows the inputs with one cycle of delay).
- R9: After a miss, poll ticks cause no read until frame_end.
- R10: miss_clr = 1 clears miss, and with it irq, on the next cycle.
- R11: buf_release while cur_owned = 1 advances cur_idx modulo (ring_last+1). The former next ownership becomes cur_owned, and the next entry becomes not owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ring_last | input | IDX_W | ring length minus one, held stable outside reset |
| poll_tick | input | 1 | poll request strobe, ignored while engaged |
| frame_start | input | 1 | a frame begins, taken only while engaged = 0 |
| addr_done | input | 1 | destination address fully received |
| addr_accept | input | 1 | address filter verdict, valid with addr_done |
| frame_end | input | 1 | the frame has finished |
| buf_release | input | 1 | current buffer handed back to software |
| irq_en | input | 1 | global interrupt enable |
| miss_mask | input | 1 | masks the missed-frame interrupt when 1 |
| miss_clr | input | 1 | write-one-to-clear of miss |
| rd_vld | input | 1 | read response valid |
| rd_own | input | 1 | ownership bit of the read descriptor |
| rd_req | output | 1 | one-cycle descriptor read request |
| rd_idx | output | IDX_W | index of the descriptor to read |
| cur_idx | output | IDX_W | current ring index |
| cur_owned | output | 1 | current buffer held by the controller |
| engaged | output | 1 | a read or a frame is in progress |
| miss | output | 1 | sticky missed-frame flag |
| irq | output | 1 | missed-frame interrupt |

## Verification
The bench goes after the poll that must stay silent when both entries are cached. A design that ignored the cache would issue reads there that nobody expects. It checks that the ring wraps: the lookahead read after the last index must go to index 0, not past the end. It tests the last-ditch path both ways. A wrong design would read more than once, miss a frame that the fresh read shows as owned, or keep polling during the missed frame. It also covers masking the interrupt, clearing miss, and a single-entry ring, where any read of a second index is an error.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WCUR  = 3'd1,
    S_WNXT  = 3'd2,
    S_ADDR  = 3'd3,
    S_WLD   = 3'd4,
    S_FRAME = 3'd5,
    S_MISS  = 3'd6
  } rxp_state_t;
endpackage

// File: rtl/rxp_ring_ptr.sv
module rxp_ring_ptr #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ring_last,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             single
);
  assign single  = (ring_last == '0);
  assign nxt_idx = (cur_idx == ring_last) ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          cur_idx <= '0;
    else if (advance) cur_idx <= nxt_idx;
  end

  p_idx_in_ring_r11: assert property (@(posedge clk) disable iff (rst)
    advance |=> (cur_idx <= ring_last));
endmodule

// File: rtl/rxp_own_cache.sv
module rxp_own_cache (
  input  logic clk,
  input  logic rst,
  input  logic ld_cur,
  input  logic ld_nxt,
  input  logic own_val,
  input  logic shift,
  input  logic single,
  output logic cur_own,
  output logic nxt_own
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_own <= 1'b0;
      nxt_own <= 1'b0;
    end else if (shift) begin
      cur_own <= single ? 1'b0 : nxt_own;
      nxt_own <= 1'b0;
    end else begin
      if (ld_cur) cur_own <= own_val;
      if (ld_nxt) nxt_own <= own_val;
    end
  end

  p_shift_moves_next_r11: assert property (@(posedge clk) disable iff (rst)
    (shift && !single) |=> (cur_own == $past(nxt_own)) && !nxt_own);
endmodule

// File: rtl/rxp_miss_irq.sv
module rxp_miss_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  input  logic miss_mask,
  output logic miss,
  output logic irq
);
  logic miss_n;
  assign miss_n = set | (miss & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      miss <= 1'b0;
      irq  <= 1'b0;
    end else begin
      miss <= miss_n;
      irq  <= miss_n & irq_en & ~miss_mask;
    end
  end

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en && !miss_mask));
  p_clear_works_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !miss);
endmodule

// File: rtl/rx_own_poller.sv
module rx_own_poller
  import rxp_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ring_last,
  input  logic             poll_tick,
  input  logic             frame_start,
  input  logic             addr_done,
  input  logic             addr_accept,
  input  logic             frame_end,
  input  logic             buf_release,
  input  logic             irq_en,
  input  logic             miss_mask,
  input  logic             miss_clr,
  input  logic             rd_vld,
  input  logic             rd_own,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_owned,
  output logic             engaged,
  output logic             miss,
  output logic             irq
);
  rxp_state_t state;
  logic [IDX_W-1:0] nxt_idx;
  logic single, nxt_own, waiting, rel, ld_cur, ld_nxt, miss_set, want_nxt;

  assign waiting  = (state == S_WCUR) || (state == S_WNXT) || (state == S_WLD);
  assign rel      = buf_release && cur_owned && !waiting;
  assign ld_cur   = rd_vld && ((state == S_WCUR) || (state == S_WLD));
  assign ld_nxt   = rd_vld && (state == S_WNXT);
  assign miss_set = rd_vld && (state == S_WLD) && !rd_own;
  assign want_nxt = !single && !nxt_own;
  assign engaged  = (state != S_IDLE);

  rxp_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .ring_last(ring_last), .advance(rel),
    .cur_idx(cur_idx), .nxt_idx(nxt_idx), .single(single)
  );

  rxp_own_cache u_cache (
    .clk(clk), .rst(rst), .ld_cur(ld_cur), .ld_nxt(ld_nxt), .own_val(rd_own),
    .shift(rel), .single(single), .cur_own(cur_owned), .nxt_own(nxt_own)
  );

  rxp_miss_irq u_miss (
    .clk(clk), .rst(rst), .set(miss_set), .clr(miss_clr),
    .irq_en(irq_en), .miss_mask(miss_mask), .miss(miss), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      rd_req <= 1'b0;
      rd_idx <= '0;
    end else begin
      rd_req <= 1'b0;
      case (state)
        S_IDLE: begin
          if (frame_start) begin
            state <= S_ADDR;
          end else if (poll_tick && !rel) begin
            if (!cur_owned) begin
              rd_req <= 1'b1;
              rd_idx <= cur_idx;
              state  <= S_WCUR;
            end else if (want_nxt) begin
              rd_req <= 1'b1;
              rd_idx <= nxt_idx;
              state  <= S_WNXT;
            end
          end
        end
        S_WCUR: begin
          if (rd_vld) begin
            if (want_nxt) begin
              rd_req <= 1'b1;
              rd_idx <= nxt_idx;
              state  <= S_WNXT;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_WNXT: if (rd_vld) state <= S_IDLE;
        S_ADDR: begin
          if (frame_end) begin
            state <= S_IDLE;
          end else if (addr_done) begin
            if (addr_accept && !cur_owned) begin
              rd_req <= 1'b1;
              rd_idx <= cur_idx;
              state  <= S_WLD;
            end else begin
              state <= S_FRAME;
            end
          end
        end
        S_WLD:   if (rd_vld) state <= rd_own ? S_FRAME : S_MISS;
        S_FRAME: if (frame_end) state <= S_IDLE;
        S_MISS:  if (frame_end) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  p_cached_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !frame_start && poll_tick && cur_owned && !want_nxt) |=> !rd_req);
  p_single_ring_idx_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && single) |-> (rd_idx == '0));
  p_quiet_after_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_MISS) |=> !rd_req);
  p_miss_from_read_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(miss) |-> $past(rd_vld && !rd_own));
  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_ADDR && addr_done && !addr_accept) |=> !rd_req);
endmodule

// File: tb/rx_own_poller_bench.sv
module rx_own_poller_bench;
  localparam int IDX_W = 3;
  localparam int NDESC = 1 << IDX_W;

  logic clk = 1'b0, rst = 1'b1;
  logic [IDX_W-1:0] ring_last = 3'd3;
  logic poll_tick = 0, frame_start = 0, addr_done = 0, addr_accept = 0, frame_end = 0;
  logic buf_release = 0, irq_en = 1, miss_mask = 0, miss_clr = 0;
  logic rd_vld = 0, rd_own = 0;
  logic rd_req, cur_owned, engaged, miss, irq;
  logic [IDX_W-1:0] rd_idx, cur_idx;

  logic mem_own [NDESC];
  logic p1 = 0;
  logic [IDX_W-1:0] pidx = '0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [IDX_W-1:0] exp_q [$];

  always #10 clk = ~clk;

  rx_own_poller #(.IDX_W(IDX_W)) u_rx_own_poller (
    .clk(clk), .rst(rst), .ring_last(ring_last), .poll_tick(poll_tick),
    .frame_start(frame_start), .addr_done(addr_done), .addr_accept(addr_accept),
    .frame_end(frame_end), .buf_release(buf_release), .irq_en(irq_en),
    .miss_mask(miss_mask), .miss_clr(miss_clr), .rd_vld(rd_vld), .rd_own(rd_own),
    .rd_req(rd_req), .rd_idx(rd_idx), .cur_idx(cur_idx), .cur_owned(cur_owned),
    .engaged(engaged), .miss(miss), .irq(irq)
  );

  // descriptor memory: answers two cycles after a request
  always @(posedge clk) begin
    p1     <= rd_req;
    pidx   <= rd_idx;
    rd_vld <= p1;
    rd_own <= mem_own[pidx];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rd_req) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected read", int'(rd_idx), -1);
      else begin
        logic [IDX_W-1:0] e;
        e = exp_q.pop_front();
        chk(rd_idx == e, "R2 read index", int'(rd_idx), int'(e));
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input int idx);
    exp_q.push_back(IDX_W'(idx));
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_reset(input logic [IDX_W-1:0] last);
    @(negedge clk);
    rst = 1; ring_last = last;
    wait_cyc(3);
    rst = 0;
    wait_cyc(1);
  endtask

  task automatic poll();
    @(negedge clk); poll_tick = 1;
    @(negedge clk); poll_tick = 0;
    wait_cyc(10);
  endtask

  task automatic release_buf();
    @(negedge clk); buf_release = 1;
    @(negedge clk); buf_release = 0;
    wait_cyc(1);
  endtask

  task automatic start_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic addr_verdict(input bit acc);
    @(negedge clk); addr_done = 1; addr_accept = acc;
    @(negedge clk); addr_done = 0; addr_accept = 0;
    wait_cyc(8);
  endtask

  task automatic end_frame();
    @(negedge clk); frame_end = 1;
    @(negedge clk); frame_end = 0;
    wait_cyc(1);
  endtask

  task automatic clear_miss();
    @(negedge clk); miss_clr = 1;
    @(negedge clk); miss_clr = 0;
  endtask

  initial begin
    for (int i = 0; i < NDESC; i++) mem_own[i] = 1'b1;
    do_reset(3'd3);
    // R1 reset state
    chk(!rd_req && !miss && !irq && !engaged, "R1 idle outputs", {rd_req, miss, irq, engaged}, 0);
    chk(cur_idx == 0 && !cur_owned, "R1 index/own", int'(cur_idx), 0);

    // R2 current then next; R11 wrap of lookahead
    expect_rd(0); expect_rd(1); poll(); drained("R2 current and next read");
    release_buf();
    chk(cur_idx == 1 && cur_owned, "R11 advance keeps next ownership", int'(cur_idx), 1);
    expect_rd(2); poll(); drained("R2 next only");
    release_buf();
    expect_rd(3); poll(); drained("R2 next only at 3");
    release_buf();
    expect_rd(0); poll(); drained("R11 lookahead wraps to 0");
    release_buf();
    chk(cur_idx == 0 && cur_owned, "R11 index wraps", int'(cur_idx), 0);

    // R4 both cached: no read
    expect_rd(1); poll(); drained("R2 fetch next");
    poll(); drained("R4 no read when both owned");

    // R6 accepted with owned current buffer
    start_frame(); addr_verdict(1'b1); end_frame();
    drained("R6 no read for owned buffer");
    chk(!miss, "R6 no miss", miss, 0);

    // move to idx 2 with nothing owned
    release_buf(); release_buf();
    chk(cur_idx == 2 && !cur_owned, "R11 next cleared on advance", int'(cur_owned), 0);
    mem_own[2] = 1'b0;

    // R5 quiet before the address verdict, then R8 miss with irq
    start_frame(); wait_cyc(6); drained("R5 quiet before addr_done");
    expect_rd(2); addr_verdict(1'b1); drained("R7 single last-ditch read");
    chk(miss, "R8 miss set", miss, 1);
    chk(irq, "R8 irq raised", irq, 1);
    poll(); drained("R9 no poll during missed frame");
    end_frame();
    chk(miss, "R8 miss sticky", miss, 1);
    clear_miss(); wait_cyc(1);
    chk(!miss && !irq, "R10 clear", {miss, irq}, 0);

    // R8 masked interrupt
    miss_mask = 1;
    start_frame(); expect_rd(2); addr_verdict(1'b1); drained("R7 last-ditch read again");
    chk(miss && !irq, "R8 masked irq", {miss, irq}, 2);
    end_frame(); clear_miss(); miss_mask = 0; wait_cyc(1);

    // R5 rejected frame
    start_frame(); addr_verdict(1'b0); end_frame();
    drained("R5 rejected frame no read");
    chk(!miss, "R5 rejected frame no miss", miss, 0);

    // R7 last-ditch succeeds
    mem_own[2] = 1'b1;
    start_frame(); expect_rd(2); addr_verdict(1'b1); drained("R7 read issued");
    chk(!miss && cur_owned, "R7 owned after last-ditch", {miss, cur_owned}, 1);
    end_frame();

    // R3 single-entry ring
    do_reset(3'd0);
    expect_rd(0); poll(); drained("R3 only index 0");
    poll(); drained("R4 single ring owned no read");
    release_buf();
    chk(cur_idx == 0 && !cur_owned, "R3 index stays 0", int'(cur_idx), 0);
    expect_rd(0); poll(); drained("R3 re-read index 0");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule